// File: doc/BRIEF.md
# Dual-Clock Mode Transition Controller

This block holds the operating mode of a display-identification memory that can be read in two ways. After reset the memory streams its lower half continuously, clocked by a dedicated stream clock. A falling edge on the two-wire bus clock moves the block into a probation state. In that state it listens for the bus address and counts stream-clock pulses. If the bus address is recognized, the block locks into two-wire bus mode. If enough stream-clock pulses arrive while the bus clock stays high, the block falls back to streaming and tells the streamer to start over.

Both clock inputs arrive already synchronized to the system clock `clk`. The address recognition comes from the two-wire slave as a single-cycle pulse. The outputs enable either the streamer or the slave's address matcher. They also report the mode and issue a one-cycle restart request to the streamer. The number of pulses that triggers recovery, the counter width and the counted stream-clock edge are parameters.

Top module: `mode_transition_ctrl`

## Requirements
- R1: After reset the mode is streaming (`mode_code` = 2'b00), `stream_en` = 1, `match_en` = 0, `trans_mode` = 0, `bidir_mode` = 0 and `stream_restart` = 0.
- R2: In streaming mode, a falling edge of `scl_lvl` (1 then 0 on consecutive cycles) moves the block to the probation mode (`mode_code` = 2'b01) on the next clock edge. Stream-clock pulses and `ctrl_match` have no effect in streaming mode.
- R3: In probation mode the block counts rising edges of `vclk_lvl`, but only those seen while `scl_lvl` is 1. Edges seen while `scl_lvl` is 0 are not counted. Each entry into probation mode starts the count at zero.
- R4: A falling edge of `scl_lvl` during probation mode clears the count to zero.
- R5: The counted edge that brings the count to RECOVER_COUNT (default 128) returns the block to streaming mode on that clock edge. `stream_restart` is 1 for exactly the one following cycle. Probation ends on the 128th counted edge and not earlier.
- R6: A `ctrl_match` pulse in probation mode moves the block to bus mode (`mode_code` = 2'b10). If it arrives in the same cycle as the recovery edge, bus mode wins and no restart is issued.
- R7: Bus mode is left only through reset. Stream-clock pulses, `scl_lvl` edges and `ctrl_match` do not change it.
- R8: `stream_en` is 1 only in streaming mode. `match_en` is 1 in probation and bus modes. `trans_mode` and `bidir_mode` flag probation and bus mode respectively, and exactly one mode is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_lvl | input | 1 | Synchronized two-wire bus clock level |
| vclk_lvl | input | 1 | Synchronized stream clock level |
| ctrl_match | input | 1 | One-cycle pulse: control byte recognized by the slave |
| stream_en | output | 1 | Enables the streamer |
| match_en | output | 1 | Enables the slave's address matching |
| trans_mode | output | 1 | Block is in probation mode |
| bidir_mode | output | 1 | Block is locked in bus mode |
| mode_code | output | 2 | 00 streaming, 01 probation, 10 bus |
| stream_restart | output | 1 | One-cycle request to restart the stream at address 0 and its MSB |

## Verification
The mode machine is driven with runs of stream-clock pulses of different lengths. The 127-pulse and 128-pulse runs separate an early exit, a late exit and a missing exit. A run interrupted by a bus-clock falling edge shows whether the count is really cleared rather than only paused. Pulses delivered while the bus clock is held low show that counting is gated on an idle bus. Address pulses applied in each mode, including one in the same cycle as the recovery edge, show that acceptance depends on the mode and that bus mode takes priority. Long pulse trains and bus edges after the lock show that the lock persists.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   typedef enum logic [1:0] {
      MODE_STREAM = 2'b00,
      MODE_PROBE  = 2'b01,
      MODE_LOCKED = 2'b10
   } mtc_mode_e;

endpackage

// File: rtl/mtc_edge.sv
module mtc_edge #(
   parameter bit RISING   = 1'b1,
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic edge_pulse
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl;
   end

   generate
      if (RISING) begin : g_rise
         assign edge_pulse = lvl & ~prev_q;
      end else begin : g_fall
         assign edge_pulse = ~lvl & prev_q;
      end
   endgenerate

endmodule

// File: rtl/mtc_pulse_counter.sv
module mtc_pulse_counter #(
   parameter int CNT_W = 8,
   parameter int LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic bus_idle,
   input  logic bus_fall,
   input  logic pulse,
   output logic hit
);

   localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             counted;

   assign counted = enable & pulse & bus_idle & ~bus_fall;
   assign hit     = counted & (cnt_q == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!enable || bus_fall)        cnt_q <= '0;
      else if (counted && cnt_q != LIM_V)  cnt_q <= cnt_q + 1'b1;
   end

   // R4: a bus falling edge while counting leaves the count at zero
   a_r4_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && bus_fall) |=> (cnt_q == '0));

   // R5: saturation, the count never passes the limit
   a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_V);

   // R3: no count movement while the bus clock is low
   a_r3_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !bus_idle && !bus_fall) |=> $stable(cnt_q));

endmodule

// File: rtl/mtc_mode_fsm.sv
module mtc_mode_fsm
   import mtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bus_fall,
   input  logic      ctrl_match,
   input  logic      recover_hit,
   output mtc_mode_e mode,
   output logic      restart
);

   mtc_mode_e mode_q, mode_d;
   logic      restart_q;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_STREAM: if (bus_fall)    mode_d = MODE_PROBE;
         MODE_PROBE: begin
            if (ctrl_match)            mode_d = MODE_LOCKED;
            else if (recover_hit)      mode_d = MODE_STREAM;
         end
         MODE_LOCKED:                  mode_d = MODE_LOCKED;
         default:                      mode_d = MODE_STREAM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_STREAM;
         restart_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         restart_q <= (mode_q == MODE_PROBE) && (mode_d == MODE_STREAM);
      end
   end

   assign mode    = mode_q;
   assign restart = restart_q;

   // R2: bus falling edge in streaming mode opens probation
   a_r2_enter_probe: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STREAM && bus_fall) |=> (mode_q == MODE_PROBE));

   // R6: address recognition in probation locks bus mode
   a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PROBE && ctrl_match) |=> (mode_q == MODE_LOCKED));

   // R7: bus mode is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LOCKED) |=> (mode_q == MODE_LOCKED));

   // R5: restart is a single-cycle pulse that follows a recovery
   a_r5_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |=> !restart_q);

   a_r5_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PROBE && recover_hit && !ctrl_match) |=> restart_q);

endmodule

// File: rtl/mode_transition_ctrl.sv
module mode_transition_ctrl
   import mtc_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int RECOVER_COUNT = 128,
   parameter bit VCLK_RISING   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_lvl,
   input  logic       vclk_lvl,
   input  logic       ctrl_match,
   output logic       stream_en,
   output logic       match_en,
   output logic       trans_mode,
   output logic       bidir_mode,
   output logic [1:0] mode_code,
   output logic       stream_restart
);

   localparam int MIN_W = $clog2(RECOVER_COUNT + 1);

   generate
      if (RECOVER_COUNT < 2) begin : g_bad_count
         $error("RECOVER_COUNT must be at least 2");
      end
      if (CNT_W < MIN_W) begin : g_bad_width
         $error("CNT_W too narrow for RECOVER_COUNT");
      end
   endgenerate

   logic      scl_fall;
   logic      vclk_edge;
   logic      hit;
   mtc_mode_e mode;

   mtc_edge #(.RISING(1'b0), .IDLE_LVL(1'b1)) u_scl_edge (
      .clk(clk), .rst_n(rst_n), .lvl(scl_lvl), .edge_pulse(scl_fall));

   mtc_edge #(.RISING(VCLK_RISING), .IDLE_LVL(~VCLK_RISING)) u_vclk_edge (
      .clk(clk), .rst_n(rst_n), .lvl(vclk_lvl), .edge_pulse(vclk_edge));

   mtc_pulse_counter #(.CNT_W(CNT_W), .LIMIT(RECOVER_COUNT)) u_count (
      .clk(clk), .rst_n(rst_n),
      .enable(mode == MODE_PROBE),
      .bus_idle(scl_lvl), .bus_fall(scl_fall),
      .pulse(vclk_edge), .hit(hit));

   mtc_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .bus_fall(scl_fall), .ctrl_match(ctrl_match),
      .recover_hit(hit), .mode(mode), .restart(stream_restart));

   assign stream_en  = (mode == MODE_STREAM);
   assign trans_mode = (mode == MODE_PROBE);
   assign bidir_mode = (mode == MODE_LOCKED);
   assign match_en   = trans_mode | bidir_mode;
   assign mode_code  = mode;

   // R8: exactly one mode flag is active
   a_r8_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({stream_en, trans_mode, bidir_mode}) == 1);

   // R8: the streamer and the address matcher are never both enabled
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(stream_en && match_en));

endmodule

// File: tb/mode_transition_ctrl_test.sv
`timescale 1ns/1ps
module mode_transition_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, vclk = 1'b0, match = 1'b0;
   logic stream_en, match_en, trans_mode, bidir_mode, stream_restart;
   logic [1:0] mode_code;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   mode_transition_ctrl uut (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl), .vclk_lvl(vclk),
      .ctrl_match(match), .stream_en(stream_en), .match_en(match_en),
      .trans_mode(trans_mode), .bidir_mode(bidir_mode),
      .mode_code(mode_code), .stream_restart(stream_restart));

   // op[11:10]: 0 stream pulses, 1 address pulse, 2 bus falling edge; n[9:2]; expected mode[1:0]
   localparam logic [11:0] VEC [0:14] = '{
      {2'd0, 8'd20,  2'b00},
      {2'd1, 8'd1,   2'b00},
      {2'd2, 8'd1,   2'b01},
      {2'd0, 8'd127, 2'b01},
      {2'd0, 8'd1,   2'b00},
      {2'd2, 8'd1,   2'b01},
      {2'd0, 8'd100, 2'b01},
      {2'd2, 8'd1,   2'b01},
      {2'd0, 8'd127, 2'b01},
      {2'd0, 8'd1,   2'b00},
      {2'd2, 8'd1,   2'b01},
      {2'd1, 8'd1,   2'b10},
      {2'd0, 8'd200, 2'b10},
      {2'd2, 8'd1,   2'b10},
      {2'd1, 8'd1,   2'b10}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_mode(input string tag, input logic [1:0] exp);
      chk({tag, " mode_code"}, mode_code, exp);
      chk({tag, " stream_en R8"}, stream_en, exp == 2'b00);
      chk({tag, " match_en R8"}, match_en, exp != 2'b00);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) vclk = 1'b1;
         @(negedge clk) vclk = 1'b0;
      end
   endtask

   task automatic bus_fall();
      @(negedge clk) scl = 1'b0;
      @(negedge clk) scl = 1'b1;
   endtask

   task automatic addr_pulse();
      @(negedge clk) match = 1'b1;
      @(negedge clk) match = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      scl = 1'b1; vclk = 1'b0; match = 1'b0;
      @(negedge clk) rst_n = 1'b1;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk_mode("R1 reset", 2'b00);
      chk("R1 trans_mode", trans_mode, 0);
      chk("R1 bidir_mode", bidir_mode, 0);
      chk("R1 restart", stream_restart, 0);

      // table walk covering R2 R3 R4 R5 R6 R7
      for (int k = 0; k < 15; k++) begin
         case (VEC[k][11:10])
            2'd0:    pulses(int'(VEC[k][9:2]));
            2'd1:    addr_pulse();
            default: bus_fall();
         endcase
         chk_mode($sformatf("table step %0d R2 R3 R4 R5 R6 R7", k), VEC[k][1:0]);
      end

      // R5: restart timing and width
      do_reset();
      bus_fall();
      pulses(127);
      chk("R5 no restart before limit", stream_restart, 0);
      @(negedge clk) vclk = 1'b1;
      @(negedge clk) vclk = 1'b0;
      chk("R5 restart high", stream_restart, 1);
      chk_mode("R5 back to stream", 2'b00);
      @(negedge clk);
      chk("R5 restart one cycle", stream_restart, 0);
      pulses(150);
      chk("R5 no second restart", stream_restart, 0);
      chk_mode("R2 stream ignores pulses", 2'b00);

      // R3: pulses with bus clock held low are not counted
      do_reset();
      @(negedge clk) scl = 1'b0;
      pulses(130);
      chk_mode("R3 held low no count", 2'b01);
      @(negedge clk) scl = 1'b1;
      pulses(127);
      chk_mode("R3 127 idle pulses", 2'b01);
      pulses(1);
      chk_mode("R3 128th idle pulse", 2'b00);

      // R3: a new probation starts from zero
      bus_fall();
      pulses(127);
      chk_mode("R3 fresh count", 2'b01);

      // R6: address pulse together with the recovery edge
      do_reset();
      bus_fall();
      pulses(127);
      @(negedge clk) begin vclk = 1'b1; match = 1'b1; end
      @(negedge clk) begin vclk = 1'b0; match = 1'b0; end
      chk_mode("R6 priority over recovery", 2'b10);
      chk("R6 no restart", stream_restart, 0);
      chk("R7 bidir flag", bidir_mode, 1);

      // R7: only reset leaves bus mode
      @(negedge clk) scl = 1'b0;
      pulses(3);
      @(negedge clk) scl = 1'b1;
      chk_mode("R7 still locked", 2'b10);
      do_reset();
      chk_mode("R7 reset leaves lock", 2'b00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule